// File: doc/BRIEF.md
# Card-Local DMA Servicing Bridge Between Serial Controller and Byte FIFOs

This block lets a serial communications controller run in its DMA mode on a card whose host slot has no usable DMA channels for it. The controller raises a transmit request when it wants a byte and a receive request when it holds one. The bridge answers both requests itself. Outgoing bytes come from a transmit FIFO, and incoming bytes go into a receive FIFO. Each FIFO holds `DEPTH` bytes (4096 by default). Only the FIFOs and a small register set are visible to the host.

The host fills the transmit FIFO and drains the receive FIFO through byte-wide IO registers. It also reads the fill levels, and it can still reach the controller's own data register directly. One interrupt line gathers three sticky causes:
- the transmit level dropping below half,
- the receive level climbing above half,
- a special condition flagged by the controller.

A three-state machine sequences the requests:
- `ARB_IDLE` picks a serviceable request. When both requests are serviceable it takes the one not granted last.
- `ARB_SERVE_TX` or `ARB_SERVE_RX` then drives a one-cycle acknowledge and moves exactly one byte.
- Both serve states always return to `ARB_IDLE`.

The IDLE-to-serve transitions are named by the request they honour: IDLE→SERVE_TX and IDLE→SERVE_RX. The serve states exit by SERVE_TX→IDLE and SERVE_RX→IDLE.

Top module: `serial_dma_bridge`

## Requirements
- R1: After reset both FIFO levels read 0, the status (address 0x2) and enable (address 0x3) registers read 0, `irq` is low and neither acknowledge is asserted.
- R2: A host write to address 0x0 appends a byte to the transmit FIFO. While `ctl_tx_req` is high and that FIFO holds data, `ctl_tx_ack` pulses for one cycle. `ctl_tx_data` carries the oldest byte during the pulse, and the transmit level drops by one.
- R3: While the transmit FIFO is empty, a pending `ctl_tx_req` gets no acknowledge. It is served once a byte arrives.
- R4: While `ctl_rx_req` is high and the receive FIFO has room, `ctl_rx_ack` pulses for one cycle and the byte on `ctl_rx_data` is stored. A host read of address 0x1 returns the oldest stored byte and removes it.
- R5: While the receive FIFO is full, a pending `ctl_rx_req` gets no acknowledge and the level stays at `DEPTH`.
- R6: No more than one acknowledge is high in any cycle. When both requests stay serviceable, the grants alternate between transmit and receive, and the first tie after reset goes to transmit.
- R7: Status bit 0 becomes 1 when the transmit level changes from `DEPTH/2` to `DEPTH/2-1`. Filling up to `DEPTH/2` does not set it.
- R8: Status bit 1 becomes 1 when the receive level changes from `DEPTH/2` to `DEPTH/2+1`. Reaching `DEPTH/2` does not set it.
- R9: A cycle with `ctl_special` high sets status bit 2.
- R10: Status bits hold until the host writes address 0x2 with a 1 in that bit position. A 0 bit leaves its status bit unchanged, and a cause arriving in the same cycle as the clear wins.
- R11: `irq` is high exactly when any of status bits 2:0 is 1 with the matching enable bit (address 0x3, bits 2:0) also 1. The enable register reads back as written.
- R12: Addresses 0x4/0x5 give the transmit level low/high byte, and 0x6/0x7 give the receive level low/high byte.
- R13: A write to a full transmit FIFO is dropped and sets status bit 3. A read of an empty receive FIFO returns 0x00, changes nothing and sets status bit 4.
- R14: A host write to address 0x8 pulses `ctl_dir_wr` with `ctl_dir_wdata` equal to the host byte. A read of 0x8 pulses `ctl_dir_rd` and returns `ctl_dir_rdata`. Neither FIFO changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| irq | output | 1 | Combined interrupt |
| ctl_tx_req | input | 1 | Controller wants a byte |
| ctl_tx_ack | output | 1 | One-cycle acknowledge with transmit byte |
| ctl_tx_data | output | 8 | Byte delivered to controller |
| ctl_rx_req | input | 1 | Controller offers a byte |
| ctl_rx_ack | output | 1 | One-cycle acknowledge taking receive byte |
| ctl_rx_data | input | 8 | Byte from controller, valid through the acknowledge |
| ctl_special | input | 1 | Special condition flag from controller |
| ctl_dir_wr | output | 1 | Direct write to controller data register |
| ctl_dir_rd | output | 1 | Direct read of controller data register |
| ctl_dir_wdata | output | 8 | Direct write byte |
| ctl_dir_rdata | input | 8 | Controller data register contents |

## Verification
The request path is driven four ways:
- **Transmit only.** A transmit-only stream separates correct FIFO ordering from any reordering.
- **Receive only.** A receive-only stream does the same for the receive FIFO.
- **Both at once.** Simultaneous requests reveal whether the grant alternates or starves one side.
- **Request with nothing to serve.** A request held against an empty or full FIFO shows whether a request is wrongly granted.

Walks of the levels across the half mark, one byte at a time, distinguish crossing detection from plain level comparison. Fills to `DEPTH` expose wrap and overflow handling. Random bursts of pushes, grants and drains, checked against bench queues, then mix all of these.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        ARB_IDLE     = 2'd0,
        ARB_SERVE_TX = 2'd1,
        ARB_SERVE_RX = 2'd2
    } arb_state_t;

    localparam logic [ADDR_W-1:0] ADDR_TXDATA   = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_RXDATA   = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS   = 4'h2;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE   = 4'h3;
    localparam logic [ADDR_W-1:0] ADDR_TXLVL_LO = 4'h4;
    localparam logic [ADDR_W-1:0] ADDR_TXLVL_HI = 4'h5;
    localparam logic [ADDR_W-1:0] ADDR_RXLVL_LO = 4'h6;
    localparam logic [ADDR_W-1:0] ADDR_RXLVL_HI = 4'h7;
    localparam logic [ADDR_W-1:0] ADDR_DIRECT   = 4'h8;

    localparam int NUM_CAUSES = 3;
    localparam int NUM_STATUS = 5;
    localparam int ST_TX_LOW  = 0;
    localparam int ST_RX_HIGH = 1;
    localparam int ST_SPECIAL = 2;
    localparam int ST_TX_OVF  = 3;
    localparam int ST_RX_UNF  = 4;

endpackage

// File: rtl/sdb_fifo.sv
module sdb_fifo #(
    parameter int DEPTH = 4096,
    parameter int WIDTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (level == '0);
    assign full    = (level == FULL_LVL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (level == $past(level)));

    assert_no_underflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (level == $past(level)));

    assert_pop_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && pop && !push) |=> (level == $past(level) - 1'b1));

    assert_level_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

endmodule

// File: rtl/sdb_arbiter.sv
module sdb_arbiter
    import sdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic rx_req,
    input  logic tx_empty,
    input  logic rx_full,
    output logic tx_ack,
    output logic rx_ack
);
    arb_state_t state;
    arb_state_t state_nx;
    logic       last_tx;
    logic       tx_ok;
    logic       rx_ok;

    assign tx_ok = tx_req && !tx_empty;
    assign rx_ok = rx_req && !rx_full;

    always_comb begin
        state_nx = ARB_IDLE;
        unique case (state)
            ARB_IDLE: begin
                if (tx_ok && rx_ok)  state_nx = last_tx ? ARB_SERVE_RX : ARB_SERVE_TX;
                else if (tx_ok)      state_nx = ARB_SERVE_TX;
                else if (rx_ok)      state_nx = ARB_SERVE_RX;
                else                 state_nx = ARB_IDLE;
            end
            ARB_SERVE_TX: state_nx = ARB_IDLE;
            ARB_SERVE_RX: state_nx = ARB_IDLE;
            default:      state_nx = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ARB_IDLE;
            last_tx <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx == ARB_SERVE_TX)      last_tx <= 1'b1;
            else if (state_nx == ARB_SERVE_RX) last_tx <= 1'b0;
        end
    end

    always_comb begin
        tx_ack = 1'b0;
        rx_ack = 1'b0;
        unique case (state)
            ARB_SERVE_TX: tx_ack = 1'b1;
            ARB_SERVE_RX: rx_ack = 1'b1;
            default: begin
                tx_ack = 1'b0;
                rx_ack = 1'b0;
            end
        endcase
    end

    assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ack && rx_ack));

    assert_alternate_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && tx_ok && rx_ok && last_tx) |=> rx_ack);

    assert_alternate_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && tx_ok && rx_ok && !last_tx) |=> tx_ack);

    assert_tx_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |=> !tx_ack);

    assert_tx_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> !tx_empty);

    assert_rx_has_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |-> !rx_full);

endmodule

// File: rtl/sdb_irq.sv
module sdb_irq
    import sdb_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LVL_W-1:0]      tx_level,
    input  logic [LVL_W-1:0]      rx_level,
    input  logic                  special,
    input  logic                  tx_ovf_evt,
    input  logic                  rx_unf_evt,
    input  logic                  clr_wr,
    input  logic [NUM_STATUS-1:0] clr_mask,
    input  logic                  en_wr,
    input  logic [NUM_CAUSES-1:0] en_data,
    output logic [NUM_STATUS-1:0] status,
    output logic [NUM_CAUSES-1:0] enable,
    output logic                  irq
);
    localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);

    logic                  tx_low;
    logic                  rx_high;
    logic                  tx_low_q;
    logic                  rx_high_q;
    logic [NUM_STATUS-1:0] set_vec;
    logic [NUM_STATUS-1:0] clr_vec;

    assign tx_low  = (tx_level < HALF_LVL);
    assign rx_high = (rx_level > HALF_LVL);

    always_comb begin
        set_vec             = '0;
        set_vec[ST_TX_LOW]  = tx_low && !tx_low_q;
        set_vec[ST_RX_HIGH] = rx_high && !rx_high_q;
        set_vec[ST_SPECIAL] = special;
        set_vec[ST_TX_OVF]  = tx_ovf_evt;
        set_vec[ST_RX_UNF]  = rx_unf_evt;
        clr_vec             = clr_wr ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_low_q  <= 1'b1;
            rx_high_q <= 1'b0;
            status    <= '0;
            enable    <= '0;
        end else begin
            tx_low_q  <= tx_low;
            rx_high_q <= rx_high;
            status    <= (status & ~clr_vec) | set_vec;
            if (en_wr) enable <= en_data;
        end
    end

    assign irq = |(status[NUM_CAUSES-1:0] & enable);

    assert_special_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        special |=> status[ST_SPECIAL]);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_TX_LOW] && !(clr_wr && clr_mask[ST_TX_LOW])) |=> status[ST_TX_LOW]);

    assert_tx_cross_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level < HALF_LVL && $past(tx_level) >= HALF_LVL) |=> status[ST_TX_LOW]);

    assert_rx_cross_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level > HALF_LVL && $past(rx_level) <= HALF_LVL) |=> status[ST_RX_HIGH]);

    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);

endmodule

// File: rtl/serial_dma_bridge.sv
module serial_dma_bridge
    import sdb_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              irq,
    input  logic              ctl_tx_req,
    output logic              ctl_tx_ack,
    output logic [BYTE_W-1:0] ctl_tx_data,
    input  logic              ctl_rx_req,
    output logic              ctl_rx_ack,
    input  logic [BYTE_W-1:0] ctl_rx_data,
    input  logic              ctl_special,
    output logic              ctl_dir_wr,
    output logic              ctl_dir_rd,
    output logic [BYTE_W-1:0] ctl_dir_wdata,
    input  logic [BYTE_W-1:0] ctl_dir_rdata
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic                  wr_stb;
    logic                  rd_stb;
    logic                  tx_push;
    logic                  rx_pop;
    logic                  tx_empty;
    logic                  tx_full;
    logic                  rx_empty;
    logic                  rx_full;
    logic [LVL_W-1:0]      tx_level;
    logic [LVL_W-1:0]      rx_level;
    logic [BYTE_W-1:0]     rx_head;
    logic [15:0]           tx_lvl_w;
    logic [15:0]           rx_lvl_w;
    logic [NUM_STATUS-1:0] status;
    logic [NUM_CAUSES-1:0] enable;

    assign wr_stb  = host_sel && host_wr;
    assign rd_stb  = host_sel && !host_wr;
    assign tx_push = wr_stb && (host_addr == ADDR_TXDATA);
    assign rx_pop  = rd_stb && (host_addr == ADDR_RXDATA);

    assign ctl_dir_wr    = wr_stb && (host_addr == ADDR_DIRECT);
    assign ctl_dir_rd    = rd_stb && (host_addr == ADDR_DIRECT);
    assign ctl_dir_wdata = host_wdata;

    sdb_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W), .LVL_W(LVL_W)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (host_wdata),
        .pop   (ctl_tx_ack),
        .rdata (ctl_tx_data),
        .empty (tx_empty),
        .full  (tx_full),
        .level (tx_level)
    );

    sdb_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W), .LVL_W(LVL_W)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ctl_rx_ack),
        .wdata (ctl_rx_data),
        .pop   (rx_pop),
        .rdata (rx_head),
        .empty (rx_empty),
        .full  (rx_full),
        .level (rx_level)
    );

    sdb_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_req   (ctl_tx_req),
        .rx_req   (ctl_rx_req),
        .tx_empty (tx_empty),
        .rx_full  (rx_full),
        .tx_ack   (ctl_tx_ack),
        .rx_ack   (ctl_rx_ack)
    );

    sdb_irq #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .special    (ctl_special),
        .tx_ovf_evt (tx_push && tx_full),
        .rx_unf_evt (rx_pop && rx_empty),
        .clr_wr     (wr_stb && (host_addr == ADDR_STATUS)),
        .clr_mask   (host_wdata[NUM_STATUS-1:0]),
        .en_wr      (wr_stb && (host_addr == ADDR_ENABLE)),
        .en_data    (host_wdata[NUM_CAUSES-1:0]),
        .status     (status),
        .enable     (enable),
        .irq        (irq)
    );

    assign tx_lvl_w = 16'(tx_level);
    assign rx_lvl_w = 16'(rx_level);

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            ADDR_RXDATA:   host_rdata = rx_empty ? '0 : rx_head;
            ADDR_STATUS:   host_rdata = BYTE_W'(status);
            ADDR_ENABLE:   host_rdata = BYTE_W'(enable);
            ADDR_TXLVL_LO: host_rdata = tx_lvl_w[7:0];
            ADDR_TXLVL_HI: host_rdata = tx_lvl_w[15:8];
            ADDR_RXLVL_LO: host_rdata = rx_lvl_w[7:0];
            ADDR_RXLVL_HI: host_rdata = rx_lvl_w[15:8];
            ADDR_DIRECT:   host_rdata = ctl_dir_rdata;
            default:       host_rdata = '0;
        endcase
    end

    assert_direct_keeps_tx_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_dir_wr && !ctl_tx_ack) |=> (tx_level == $past(tx_level)));

endmodule

// File: tb/serial_dma_bridge_bench.sv
`timescale 1ns/1ps
module serial_dma_bridge_bench;
    localparam int DEPTH = 4096;
    localparam int HALF  = DEPTH / 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_sel, host_wr;
    logic [3:0] host_addr;
    logic [7:0] host_wdata, host_rdata;
    logic       irq;
    logic       ctl_tx_req, ctl_tx_ack;
    logic [7:0] ctl_tx_data;
    logic       ctl_rx_req, ctl_rx_ack;
    logic [7:0] ctl_rx_data;
    logic       ctl_special, ctl_dir_wr, ctl_dir_rd;
    logic [7:0] ctl_dir_wdata, ctl_dir_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    int grant_log[$];

    always #10 clk = ~clk;

    serial_dma_bridge #(.DEPTH(DEPTH)) u_serial_dma_bridge (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .ctl_tx_req(ctl_tx_req), .ctl_tx_ack(ctl_tx_ack), .ctl_tx_data(ctl_tx_data),
        .ctl_rx_req(ctl_rx_req), .ctl_rx_ack(ctl_rx_ack), .ctl_rx_data(ctl_rx_data),
        .ctl_special(ctl_special), .ctl_dir_wr(ctl_dir_wr), .ctl_dir_rd(ctl_dir_rd),
        .ctl_dir_wdata(ctl_dir_wdata), .ctl_dir_rdata(ctl_dir_rdata)
    );

    function automatic int exp_irq(input logic [7:0] st, input logic [7:0] en);
        return int'(|(st[2:0] & en[2:0]));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hr(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        hw(4'h0, d);
        if (txq.size() < DEPTH) txq.push_back(d);
    endtask

    task automatic rd_level(input bit is_rx, output int lvl);
        logic [7:0] lo, hi;
        hr(is_rx ? 4'h6 : 4'h4, lo);
        hr(is_rx ? 4'h7 : 4'h5, hi);
        lvl = int'({hi, lo});
    endtask

    task automatic pop_rx_check(input int m);
        logic [7:0] d;
        for (int i = 0; i < m; i++) begin
            hr(4'h1, d);
            if (rxq.size() > 0) chk("R4 rx byte order", d, rxq.pop_front());
            else chk("R4 rx model empty", 1, 0);
        end
    endtask

    task automatic dma_run(input int n_tx, input int n_rx);
        int  guard = 0;
        bit  chg   = 0;
        @(negedge clk);
        ctl_tx_req = (n_tx > 0);
        ctl_rx_req = (n_rx > 0);
        while ((n_tx > 0 || n_rx > 0) && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (chg) begin ctl_rx_data = 8'($urandom); chg = 0; end
            if (ctl_tx_ack && ctl_rx_ack) chk("R6 single grant per cycle", 1, 0);
            if (ctl_tx_ack) begin
                if (txq.size() > 0) chk("R2 tx byte order", ctl_tx_data, txq.pop_front());
                else chk("R3 ack with empty model", 1, 0);
                grant_log.push_back(0);
                n_tx--;
                if (n_tx <= 0) ctl_tx_req = 1'b0;
            end
            if (ctl_rx_ack) begin
                rxq.push_back(ctl_rx_data);
                grant_log.push_back(1);
                n_rx--;
                if (n_rx <= 0) ctl_rx_req = 1'b0;
                chg = 1;
            end
        end
        if (guard >= 20000) chk("R2 R4 dma stalled", 1, 0);
        ctl_tx_req = 1'b0;
        ctl_rx_req = 1'b0;
        repeat (3) @(negedge clk);
        if (chg) ctl_rx_data = 8'($urandom);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] st;
        int lvl;
        int acks;
        void'($urandom(32'd24681357));
        rst_n = 1'b0; host_sel = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
        ctl_tx_req = 0; ctl_rx_req = 0; ctl_rx_data = 8'h11; ctl_special = 0;
        ctl_dir_rdata = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq after reset", irq, 0);
        chk("R1 tx ack after reset", ctl_tx_ack, 0);
        chk("R1 rx ack after reset", ctl_rx_ack, 0);
        hr(4'h2, d); chk("R1 status after reset", d, 0);
        hr(4'h3, d); chk("R1 enable after reset", d, 0);
        rd_level(0, lvl); chk("R1 tx level after reset", lvl, 0);
        rd_level(1, lvl); chk("R1 rx level after reset", lvl, 0);

        // R3 request against empty transmit FIFO
        @(negedge clk); ctl_tx_req = 1'b1; acks = 0;
        repeat (12) begin @(negedge clk); if (ctl_tx_ack) acks++; end
        chk("R3 no ack while tx empty", acks, 0);
        push_tx(8'hA7);
        acks = 0;
        repeat (4) begin @(negedge clk); if (ctl_tx_ack) begin acks++; chk("R3 late byte", ctl_tx_data, 8'hA7); end end
        ctl_tx_req = 1'b0;
        chk("R3 served after byte arrives", acks, 1);
        void'(txq.pop_front());

        // R2 transmit ordering
        for (int i = 0; i < 5; i++) push_tx(8'($urandom));
        rd_level(0, lvl); chk("R12 tx level after 5 pushes", lvl, 5);
        dma_run(5, 0);
        rd_level(0, lvl); chk("R2 tx level drained", lvl, 0);

        // R4 receive path
        dma_run(0, 6);
        rd_level(1, lvl); chk("R12 rx level after 6", lvl, 6);
        pop_rx_check(6);
        rd_level(1, lvl); chk("R4 rx level drained", lvl, 0);

        // R6 alternation with both pending, last grant was receive
        for (int i = 0; i < 4; i++) push_tx(8'($urandom));
        grant_log.delete();
        dma_run(4, 4);
        chk("R6 grant count", grant_log.size(), 8);
        for (int i = 0; i < 8 && i < grant_log.size(); i++)
            chk("R6 alternating grant", grant_log[i], i % 2);
        pop_rx_check(4);

        // R14 direct access
        @(negedge clk);
        host_sel = 1; host_wr = 1; host_addr = 4'h8; host_wdata = 8'h5A;
        #1;
        chk("R14 direct write strobe", ctl_dir_wr, 1);
        chk("R14 direct write byte", ctl_dir_wdata, 8'h5A);
        @(negedge clk); host_sel = 0; host_wr = 0;
        #1 chk("R14 direct write strobe ends", ctl_dir_wr, 0);
        ctl_dir_rdata = 8'hC3;
        @(negedge clk); host_sel = 1; host_wr = 0; host_addr = 4'h8;
        #1;
        chk("R14 direct read strobe", ctl_dir_rd, 1);
        chk("R14 direct read byte", host_rdata, 8'hC3);
        @(negedge clk); host_sel = 0;
        rd_level(0, lvl); chk("R14 tx fifo untouched", lvl, 0);
        rd_level(1, lvl); chk("R14 rx fifo untouched", lvl, 0);

        // R11 enable, R9 special, R10 clear
        hw(4'h3, 8'h07);
        hr(4'h3, d); chk("R11 enable readback", d, 7);
        hw(4'h2, 8'h1F);
        @(negedge clk); ctl_special = 1; @(negedge clk); ctl_special = 0;
        repeat (2) @(negedge clk);
        hr(4'h2, st); chk("R9 special sets bit2", st[2], 1);
        chk("R11 irq with special", irq, exp_irq(st, 8'h07));
        hw(4'h2, 8'h00);
        hr(4'h2, st); chk("R10 zero write keeps bit2", st[2], 1);
        hw(4'h3, 8'h03);
        #1 chk("R11 irq masked", irq, 0);
        hw(4'h3, 8'h07);
        hw(4'h2, 8'h04);
        hr(4'h2, st); chk("R10 clear bit2", st, 0);
        #1 chk("R11 irq after clear", irq, 0);

        // R7 transmit crossing below half
        for (int i = 0; i < HALF; i++) push_tx(8'($urandom));
        rd_level(0, lvl); chk("R12 tx level at half", lvl, HALF);
        hr(4'h2, st); chk("R7 no set while filling", st[0], 0);
        dma_run(1, 0);
        hr(4'h2, st); chk("R7 set on crossing", st[0], 1);
        chk("R11 irq on tx low", irq, exp_irq(st, 8'h07));
        dma_run(HALF - 1, 0);
        hw(4'h2, 8'h1F);

        // R8 receive crossing above half
        dma_run(0, HALF);
        hr(4'h2, st); chk("R8 no set at half", st[1], 0);
        dma_run(0, 1);
        hr(4'h2, st); chk("R8 set on crossing", st[1], 1);
        rd_level(1, lvl); chk("R12 rx level above half", lvl, HALF + 1);
        dma_run(0, HALF - 1);
        rd_level(1, lvl); chk("R12 rx level full", lvl, DEPTH);

        // R5 full receive FIFO
        @(negedge clk); ctl_rx_req = 1'b1; acks = 0;
        repeat (12) begin @(negedge clk); if (ctl_rx_ack) acks++; end
        ctl_rx_req = 1'b0;
        chk("R5 no ack while rx full", acks, 0);
        rd_level(1, lvl); chk("R5 rx level held", lvl, DEPTH);

        // R13 receive underflow
        pop_rx_check(DEPTH);
        hw(4'h2, 8'h1F);
        hr(4'h1, d); chk("R13 empty read returns zero", d, 0);
        hr(4'h2, st); chk("R13 underflow flag", st[4], 1);
        rd_level(1, lvl); chk("R13 rx level stays zero", lvl, 0);

        // R13 transmit overflow
        for (int i = 0; i < DEPTH; i++) push_tx(8'(i * 7 + 3));
        hr(4'h2, st); chk("R13 no overflow while filling", st[3], 0);
        hw(4'h0, 8'hEE);
        hr(4'h2, st); chk("R13 overflow flag", st[3], 1);
        rd_level(0, lvl); chk("R13 tx level capped", lvl, DEPTH);
        dma_run(DEPTH, 0);
        rd_level(0, lvl); chk("R13 dropped byte absent", lvl, 0);

        // random mix
        for (int r = 0; r < 30; r++) begin
            int k, ntx, nrx, m;
            k = $urandom_range(0, 24);
            for (int i = 0; i < k; i++) push_tx(8'($urandom));
            ntx = $urandom_range(0, txq.size());
            nrx = $urandom_range(0, 24);
            dma_run(ntx, nrx);
            m = $urandom_range(0, rxq.size());
            pop_rx_check(m);
        end
        rd_level(0, lvl); chk("R12 random tx level", lvl, txq.size());
        rd_level(1, lvl); chk("R12 random rx level", lvl, rxq.size());
        dma_run(txq.size(), 0);
        pop_rx_check(rxq.size());
        hr(4'h2, st);
        chk("R11 final irq", irq, exp_irq(st, 8'h07));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule